// File: doc/BRIEF.md
# Destination address hash filter

This block decides, frame by frame, whether a receive path should keep an incoming frame, looking only at the frame's destination address. The address arrives as a stream of bytes, first byte first, qualified by a valid strobe; a start strobe marks the first byte. One clock after the last address byte the block raises a one-cycle decision strobe together with an accept flag.

Individual (unicast) destinations must equal a programmed station address exactly. Group (multicast) destinations are hashed: a bit-reflected CRC-32 is run over the address bytes, and the top six bits of its complement pick one bit of a 64-bit table. The broadcast address is always kept, and a pass-all input keeps everything. The station address and the two halves of the table are loaded through a small register write port.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset `out_valid` is 0 and all four registers are zero, so a group destination (other than broadcast) is rejected until a table bit is written.
- R2: `out_valid` is high for exactly the one cycle after the clock edge that takes the sixth address byte, once per address, and low at all other times.
- R3: An address whose first byte has bit 0 clear is accepted only when all six bytes equal the station address; byte 0 is compared with select-0 register bits 7:0, byte 1 with 15:8, byte 2 with 23:16, byte 3 with 31:24, byte 4 with select-1 register bits 7:0 and byte 5 with bits 15:8.
- R4: The address FF:FF:FF:FF:FF:FF is accepted whatever the table and station contents.
- R5: An address whose first byte has bit 0 set is accepted when the table bit indexed by the hash is 1, and rejected when it is 0. The hash: a 32-bit register starts at all ones; for each byte, first byte first, each bit LSB first, the register shifts left one place and is XORed with 0x04C11DB7 when its old bit 31 differed from the data bit; after six bytes the register is inverted and its bits 31:26 are the index.
- R6: Hash index 0 to 31 selects that bit of the select-2 register; index 32 to 63 selects bit (index - 32) of the select-3 register.
- R7: When `pass_all` is 1 at the edge that takes the sixth byte, the address is accepted.
- R8: A byte taken with `in_start` high always becomes byte 0 of a new address, discarding any partly received address.
- R9: Cycles with `in_valid` low are skipped, so gaps between address bytes are allowed; bytes with `in_valid` high after a complete address and without `in_start` are ignored and produce no decision.
- R10: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel` (0 station low, 1 station high using `cfg_wdata[15:0]`, 2 table low, 3 table high) at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select (0 to 3) |
| cfg_wdata | input | 32 | Register write data |
| pass_all | input | 1 | Accept every address |
| in_valid | input | 1 | Address byte valid |
| in_start | input | 1 | Marks the first byte of an address |
| in_byte | input | 8 | Address byte |
| out_valid | output | 1 | Decision strobe |
| out_accept | output | 1 | Keep the frame (meaningful with out_valid) |

## Verification
The bench builds the block with its defaults: six address bytes, a six-bit hash and 32-bit registers, which splits the table into exactly two registers. Those values put both halves of the table within reach, so the bench can place a single bit either in the indexed position or at the same offset in the other half and see the decision follow. Six bytes also leave room for restarts after one to five bytes and for gaps between bytes before the last one.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int unsigned DAF_CRC_W = 32;
  localparam logic [DAF_CRC_W-1:0] DAF_POLY = 32'h04C11DB7;
  localparam int unsigned DAF_BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_STA_LO = 2'd0,
    SEL_STA_HI = 2'd1,
    SEL_TBL_LO = 2'd2,
    SEL_TBL_HI = 2'd3
  } daf_sel_e;
endpackage

// File: rtl/daf_crc_byte.sv
module daf_crc_byte #(
  parameter int unsigned CRC_W = daf_pkg::DAF_CRC_W,
  parameter logic [CRC_W-1:0] POLY = daf_pkg::DAF_POLY,
  parameter int unsigned BYTE_W = daf_pkg::DAF_BYTE_W
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_in;

  // one shift per data bit, least significant data bit first
  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][CRC_W-1] ^ data[b];
    assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/daf_regs.sv
module daf_regs #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned STA_W    = 48,
  parameter int unsigned TBL_REGS = 2,
  parameter int unsigned SEL_W    = 2,
  localparam int unsigned TBL_W   = TBL_REGS * REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] wdata,
  output logic [STA_W-1:0] sta,
  output logic [TBL_W-1:0] tbl
);
  localparam int unsigned HI_W = STA_W - REG_W;

  logic [REG_W-1:0] sta_lo_q;
  logic [HI_W-1:0]  sta_hi_q;
  logic [REG_W-1:0] tbl_r [TBL_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
    end else if (we) begin
      if (sel == SEL_W'(0)) sta_lo_q <= wdata;
      if (sel == SEL_W'(1)) sta_hi_q <= wdata[HI_W-1:0];
    end
  end

  // table words sit above the two station selects
  for (genvar k = 0; k < TBL_REGS; k++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (rst)
        tbl_r[k] <= '0;
      else if (we && sel == SEL_W'(k + 2))
        tbl_r[k] <= wdata;
    end
    assign tbl[k*REG_W +: REG_W] = tbl_r[k];
  end

  assign sta = {sta_hi_q, sta_lo_q};
endmodule

// File: rtl/daf_capture.sv
module daf_capture #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  parameter int unsigned CRC_W      = daf_pkg::DAF_CRC_W,
  localparam int unsigned AW        = 8 * ADDR_BYTES,
  localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic [7:0]           in_byte,
  output logic                 fin,
  output logic [AW-1:0]        addr_full,
  output logic [HASH_BITS-1:0] hash_idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q, crc_src, crc_nx;
  logic [7:0]       addr_r [ADDR_BYTES-1];
  logic             take;
  logic [CNT_W-1:0] slot;

  // cnt_q == 0 means idle (no address in progress)
  assign take = in_valid && (in_start || cnt_q != '0);
  assign slot = in_start ? '0 : cnt_q;
  assign fin  = in_valid && !in_start && (cnt_q == LAST);

  assign crc_src = in_start ? '1 : crc_q;

  daf_crc_byte #(.CRC_W(CRC_W)) u_step (
    .crc_in (crc_src),
    .data   (in_byte),
    .crc_out(crc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      crc_q <= '1;
    end else if (take) begin
      crc_q <= crc_nx;
      if (fin) cnt_q <= '0;
      else     cnt_q <= slot + CNT_W'(1);
    end
  end

  for (genvar s = 0; s < ADDR_BYTES - 1; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        addr_r[s] <= '0;
      else if (take && slot == CNT_W'(s))
        addr_r[s] <= in_byte;
    end
    assign addr_full[8*s +: 8] = addr_r[s];
  end

  // the last byte is used straight from the input
  assign addr_full[AW-1 -: 8] = in_byte;
  assign hash_idx = ~crc_nx[CRC_W-1 -: HASH_BITS];
endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
  parameter int unsigned AW        = 48,
  parameter int unsigned HASH_BITS = 6,
  localparam int unsigned TBL_W    = 1 << HASH_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fin,
  input  logic [AW-1:0]        addr,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic [AW-1:0]        sta,
  input  logic [TBL_W-1:0]     tbl,
  input  logic                 pass_all,
  output logic                 out_valid,
  output logic                 out_accept
);
  logic is_group, is_bcast, grp_hit, uni_hit, keep;

  assign is_group = addr[0];
  assign is_bcast = &addr;
  assign grp_hit  = tbl[hash_idx];
  assign uni_hit  = (addr == sta);
  assign keep     = pass_all || is_bcast || (is_group ? grp_hit : uni_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
    end else begin
      out_valid  <= fin;
      out_accept <= fin && keep;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  parameter int unsigned REG_W      = 32,
  localparam int unsigned AW        = 8 * ADDR_BYTES,
  localparam int unsigned TBL_REGS  = (1 << HASH_BITS) / REG_W,
  localparam int unsigned SEL_W     = $clog2(TBL_REGS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             pass_all,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic             out_accept
);
  localparam int unsigned TBL_W = TBL_REGS * REG_W;

  logic [AW-1:0]        sta;
  logic [TBL_W-1:0]     tbl;
  logic                 fin;
  logic [AW-1:0]        addr_full;
  logic [HASH_BITS-1:0] hash_idx;

  daf_regs #(
    .REG_W(REG_W), .STA_W(AW), .TBL_REGS(TBL_REGS), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .sta(sta), .tbl(tbl)
  );

  daf_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_byte(in_byte), .fin(fin), .addr_full(addr_full), .hash_idx(hash_idx)
  );

  daf_decide #(.AW(AW), .HASH_BITS(HASH_BITS)) u_dec (
    .clk(clk), .rst(rst), .fin(fin), .addr(addr_full), .hash_idx(hash_idx),
    .sta(sta), .tbl(tbl), .pass_all(pass_all),
    .out_valid(out_valid), .out_accept(out_accept)
  );
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned REG_W      = 32,
  localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             pass_all,
  input logic             in_valid,
  input logic             in_start,
  input logic [7:0]       in_byte,
  input logic             out_valid,
  input logic             out_accept
);
  // independent port-level model of address framing
  logic [CNT_W-1:0] cc_q;
  logic ev, ev_q, allff_q, bc_q, grp_q, grp_ev_q, tbl_set_q;

  assign ev = in_valid && !in_start && cc_q == CNT_W'(ADDR_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0; ev_q <= 1'b0; allff_q <= 1'b0; bc_q <= 1'b0;
      grp_q <= 1'b0; grp_ev_q <= 1'b0; tbl_set_q <= 1'b0;
    end else begin
      ev_q <= ev;
      if (cfg_we && cfg_sel >= SEL_W'(2) && cfg_wdata != '0) tbl_set_q <= 1'b1;
      if (in_valid && in_start) begin
        cc_q    <= CNT_W'(1);
        allff_q <= (in_byte == 8'hFF);
        grp_q   <= in_byte[0];
      end else if (in_valid && cc_q != '0) begin
        if (ev) begin
          cc_q     <= '0;
          bc_q     <= allff_q && in_byte == 8'hFF;
          grp_ev_q <= grp_q && !(allff_q && in_byte == 8'hFF);
        end else begin
          cc_q    <= cc_q + CNT_W'(1);
          allff_q <= allff_q && in_byte == 8'hFF;
        end
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r2_strobe_timing: assert property (@(posedge clk) disable iff (rst)
    out_valid == ev_q);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r4_broadcast_kept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bc_q) |-> out_accept);

  a_r7_pass_all_kept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pass_all)) |-> out_accept);

  a_r1_empty_table_drops: assert property (@(posedge clk) disable iff (rst)
    (out_valid && grp_ev_q && !tbl_set_q && !$past(pass_all)) |-> !out_accept);
endmodule

bind dest_addr_filter daf_checker #(
  .ADDR_BYTES(ADDR_BYTES), .SEL_W(SEL_W), .REG_W(REG_W)
) u_daf_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .pass_all(pass_all), .in_valid(in_valid),
  .in_start(in_start), .in_byte(in_byte), .out_valid(out_valid),
  .out_accept(out_accept)
);

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic pass_all = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0;
  logic [7:0] in_byte = '0;
  logic out_valid, out_accept;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dest_addr_filter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pass_all(pass_all), .in_valid(in_valid),
    .in_start(in_start), .in_byte(in_byte), .out_valid(out_valid),
    .out_accept(out_accept)
  );

  // byte k of an address sits at bits 8k+7:8k
  localparam logic [47:0] STA   = 48'h55_44_33_22_11_02;
  localparam logic [47:0] GRP_A = 48'h01_00_00_5E_00_01;
  localparam logic [47:0] GRP_B = 48'hFB_00_00_00_33_33;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

  typedef struct packed {
    logic [47:0] a;
    logic        pa;
    logic [1:0]  hm;   // 0 empty table, 1 all but own bit, 2 only own bit
    logic [1:0]  gap;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{STA,                  1'b0, 2'd0, 2'd0, 1'b1}, // R3 exact match
    '{48'h56_44_33_22_11_02, 1'b0, 2'd2, 2'd0, 1'b0}, // R3 last byte differs
    '{48'h55_44_33_22_11_04, 1'b0, 2'd2, 2'd1, 1'b0}, // R3 first byte differs
    '{GRP_A,                1'b0, 2'd2, 2'd0, 1'b1}, // R5 own bit set
    '{GRP_A,                1'b0, 2'd1, 2'd0, 1'b0}, // R5 only own bit clear
    '{GRP_B,                1'b0, 2'd0, 2'd0, 1'b0}, // R5 empty table
    '{BCAST,                1'b0, 2'd0, 2'd0, 1'b1}, // R4 broadcast
    '{48'h00_00_00_00_00_0A, 1'b1, 2'd0, 2'd0, 1'b1}, // R7 pass_all
    '{GRP_B,                1'b0, 2'd2, 2'd2, 1'b1}, // R9 gaps, R5 hit
    '{GRP_B,                1'b1, 2'd1, 2'd3, 1'b1}  // R7 overrides miss
  };

  function automatic logic [5:0] model_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ a[8*k + b];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    c = ~c;
    return c[31:26];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_table(input logic [63:0] t);
    wr(2'd2, t[31:0]);
    wr(2'd3, t[63:32]);
  endtask

  task automatic push(input logic [7:0] b, input logic st);
    @(negedge clk);
    in_valid = 1'b1; in_start = st; in_byte = b;
  endtask

  task automatic idle_cyc;
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  // sends one address, returns strobe and flag seen one cycle after byte 5
  task automatic send(input logic [47:0] a, input int gap,
                      output logic v, output logic acc);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) for (int g = 0; g < gap; g++) idle_cyc();
      push(a[8*k +: 8], k == 0);
      if (k == 5) check(out_valid, 1'b0, "R2 early strobe");
    end
    idle_cyc();
    v = out_valid; acc = out_accept;
    @(negedge clk);
    check(out_valid, 1'b0, "R2 strobe longer than one cycle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic v, acc;
    logic [63:0] t;
    logic [5:0] ix;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(out_valid, 1'b0, "R1 out_valid after reset");

    // R1: registers cleared, group address rejected before any table write
    send(GRP_A, 0, v, acc);
    check(v, 1'b1, "R1 strobe");
    check(acc, 1'b0, "R1 group with cleared table");
    send(STA, 0, v, acc);
    check(acc, 1'b0, "R1 station cleared, unicast rejected");

    // R10: station load through the register port
    wr(2'd0, STA[31:0]);
    wr(2'd1, {16'h0, STA[47:32]});

    foreach (VECS[i]) begin
      ix = model_idx(VECS[i].a);
      t = 64'h1 << ix;
      case (VECS[i].hm)
        2'd0: load_table(64'h0);
        2'd1: load_table(~t);
        default: load_table(t);
      endcase
      pass_all = VECS[i].pa;
      send(VECS[i].a, int'(VECS[i].gap), v, acc);
      check(v, 1'b1, $sformatf("R2 strobe vector %0d", i));
      check(acc, VECS[i].exp, $sformatf("R3/R4/R5/R7/R9 vector %0d", i));
    end
    pass_all = 1'b0;

    // R6: own bit accepts, same offset in the other half rejects
    for (int k = 0; k < 16; k++) begin
      logic [47:0] a = {8'(k), 40'h00_00_5E_00_01};
      ix = model_idx(a);
      load_table(64'h1 << ix);
      send(a, 0, v, acc);
      check(acc, 1'b1, $sformatf("R6 idx %0d own half", ix));
      load_table(64'h1 << (ix ^ 6'd32));
      send(a, 0, v, acc);
      check(acc, 1'b0, $sformatf("R6 idx %0d other half", ix));
    end

    // R8: restart after three bytes of a group address
    load_table(64'h0);
    push(8'h01, 1'b1); push(8'h00, 1'b0); push(8'h5E, 1'b0);
    send(STA, 0, v, acc);
    check(v, 1'b1, "R8 strobe after restart");
    check(acc, 1'b1, "R8 restarted station address");

    // R8: restart after five bytes, new address is a mismatching unicast
    push(8'hFF, 1'b1);
    for (int k = 1; k < 5; k++) push(8'hFF, 1'b0);
    send(48'h55_44_33_22_11_06, 0, v, acc);
    check(v, 1'b1, "R8 strobe after late restart");
    check(acc, 1'b0, "R8 partial broadcast discarded");

    // R9: trailing bytes without start make no decision
    send(BCAST, 0, v, acc);
    for (int k = 0; k < 7; k++) begin
      push(8'(k), 1'b0);
      check(out_valid, 1'b0, "R9 stray byte");
    end
    idle_cyc();
    check(out_valid, 1'b0, "R9 stray byte tail");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule